// File: doc/BRIEF.md
# Page Write Staging Buffer and Page Programming Engine

This block sits behind a serial memory slave front end and turns a stream of data bytes into one whole-page programming cycle. A start request latches a 16-bit starting address: the upper nine bits pick the page, and the lower seven bits seed an in-page byte counter. Each loaded byte goes into a one-page staging buffer at the counter position. A per-byte valid flag marks the position as loaded, and the counter then steps forward. The counter wraps inside the page, so a long burst overwrites its own earlier bytes and never moves to the next page.

A commit request starts a timed internal write. The engine walks all 128 locations of the addressed page. For each location it reads the stored byte and writes back either the staged byte, if that position was loaded, or the old value. Busy stays high for a fixed, parameterised number of cycles, and while busy every request is dropped. The array is a synchronous RAM that starts erased. It holds only a few pages for simulation, so page numbers alias modulo that count. A registered read port lets the surrounding logic inspect the array.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, busy_o is 0, cur_ptr_o is 0, and every array byte reads as 0xFF.
- R2: An accepted start sets cur_ptr_o to start_addr_i[6:0] on the next cycle, selects page start_addr_i[15:7], and clears all valid flags.
- R3: Each accepted load writes load_data_i at the counter position and then adds one to cur_ptr_o, wrapping from 127 to 0. The page never changes.
- R4: When more than 128 bytes are loaded in one transaction, a position that is loaded again keeps the later byte.
- R5: A commit accepted while at least one byte is valid raises busy_o on the next cycle. busy_o then stays high for exactly WRITE_CYCLES cycles.
- R6: After the write cycle, every loaded location of the page holds its staged byte. Every other location of that page, and every location of other pages, keeps its previous value.
- R7: While busy_o is high, start, load and commit requests have no effect. When the cycle ends, all valid flags are cleared.
- R8: A commit with no valid byte leaves busy_o low and changes no array byte.
- R9: rd_data_o returns, one cycle after rd_addr_i is applied, the byte at page rd_addr_i[15:7] modulo MEM_PAGES and offset rd_addr_i[6:0].
- R10: Requests in the same cycle are served by priority: start first, then commit, then load. A load that arrives with a start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transaction at start_addr_i |
| start_addr_i | input | 16 | Page (15:7) and byte offset (6:0) |
| load_i | input | 1 | Stage one data byte |
| load_data_i | input | 8 | Byte to stage |
| commit_i | input | 1 | Start the page write cycle |
| busy_o | output | 1 | Internal write cycle in progress |
| cur_ptr_o | output | 7 | Current in-page byte counter |
| rd_addr_i | input | 16 | Array read address |
| rd_data_o | output | 8 | Registered array read data |

## Verification
A wrong counter appears on cur_ptr_o one cycle after the offending start or load. A wrong busy timer shows up as busy_o falling early or late, within the same cycle as the commit window. A wrong valid flag, or a fault in the merge path, shows only after the cycle ends, as a wrong byte at the read port: a location that lost its old value, or a staged byte that never landed. For that reason every written page and its neighbours are read back in full after each cycle, and the per-cycle reference comparison pins the counter and busy faults to the exact cycle.

// File: rtl/ppe_pkg.sv
package ppe_pkg;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_START  = 2'd1,
      CMD_COMMIT = 2'd2,
      CMD_LOAD   = 2'd3
   } ppe_cmd_e;

   // start outranks commit, commit outranks load; nothing is taken while busy
   function automatic ppe_cmd_e decode_cmd(input logic start,
                                           input logic commit,
                                           input logic load,
                                           input logic busy);
      ppe_cmd_e c;
      c = CMD_NONE;
      if (!busy) begin
         if (start)       c = CMD_START;
         else if (commit) c = CMD_COMMIT;
         else if (load)   c = CMD_LOAD;
      end
      return c;
   endfunction

endpackage

// File: rtl/ppe_stage_buf.sv
module ppe_stage_buf #(
   parameter int DATA_W = 8,
   parameter int OFF_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OFF_W-1:0]  start_off_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              clear_i,
   input  logic [OFF_W-1:0]  sel_idx_i,
   output logic [OFF_W-1:0]  ptr_o,
   output logic              any_valid_o,
   output logic [DATA_W-1:0] sel_data_o,
   output logic              sel_valid_o
);
   localparam int ENTRIES = 1 << OFF_W;

   logic [OFF_W-1:0]  ptr_q;
   logic [ENTRIES-1:0] vld_q;
   logic [DATA_W-1:0] dat_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q <= '0;
      else if (start_i) ptr_q <= start_off_i;
      else if (load_i)  ptr_q <= ptr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 vld_q <= '0;
      else if (start_i || clear_i) vld_q <= '0;
      else if (load_i)            vld_q[ptr_q] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (load_i) dat_q[ptr_q] <= load_data_i;
   end

   assign ptr_o       = ptr_q;
   assign any_valid_o = |vld_q;
   assign sel_valid_o = vld_q[sel_idx_i];
   assign sel_data_o  = dat_q[sel_idx_i];
endmodule

// File: rtl/ppe_array.sv
module ppe_array #(
   parameter int DATA_W      = 8,
   parameter int AW          = 9,
   parameter bit INIT_ERASED = 1'b1
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [AW-1:0]     raddr_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [AW-1:0]     raddr_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (INIT_ERASED) begin : g_erased
         initial begin
            for (int i = 0; i < DEPTH; i++) mem[i] = '1;
         end
      end else begin : g_zero
         initial begin
            for (int i = 0; i < DEPTH; i++) mem[i] = '0;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge clk) begin
      rdata_a_o <= mem[raddr_a_i];
      rdata_b_o <= mem[raddr_b_i];
   end
endmodule

// File: rtl/ppe_sequencer.sv
module ppe_sequencer #(
   parameter int OFF_W        = 7,
   parameter int WRITE_CYCLES = 160
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   output logic             busy_o,
   output logic [OFF_W-1:0] rd_idx_o,
   output logic             wr_en_o,
   output logic [OFF_W-1:0] wr_idx_o,
   output logic             done_o
);
   localparam int TW = $clog2(WRITE_CYCLES + 1);

   logic             busy_q;
   logic [TW-1:0]    tmr_q;
   logic             scan_q;
   logic [OFF_W-1:0] scan_idx_q;
   logic             wr_pend_q;
   logic [OFF_W-1:0] wr_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         tmr_q      <= '0;
         scan_q     <= 1'b0;
         scan_idx_q <= '0;
         wr_pend_q  <= 1'b0;
         wr_idx_q   <= '0;
      end else begin
         wr_pend_q <= scan_q;
         wr_idx_q  <= scan_idx_q;
         if (go_i) begin
            busy_q     <= 1'b1;
            tmr_q      <= TW'(WRITE_CYCLES - 1);
            scan_q     <= 1'b1;
            scan_idx_q <= '0;
         end else begin
            if (busy_q) begin
               if (tmr_q == '0) busy_q <= 1'b0;
               else             tmr_q  <= tmr_q - 1'b1;
            end
            if (scan_q) begin
               scan_idx_q <= scan_idx_q + 1'b1;
               if (scan_idx_q == '1) scan_q <= 1'b0;
            end
         end
      end
   end

   assign busy_o   = busy_q;
   assign rd_idx_o = scan_idx_q;
   assign wr_en_o  = wr_pend_q;
   assign wr_idx_o = wr_idx_q;
   assign done_o   = busy_q && (tmr_q == '0);
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 16,
   parameter int OFF_W        = 7,
   parameter int MEM_PAGES    = 4,
   parameter int WRITE_CYCLES = 160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   input  logic              commit_i,
   output logic              busy_o,
   output logic [OFF_W-1:0]  cur_ptr_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   import ppe_pkg::*;

   localparam int PAGE_BYTES = 1 << OFF_W;
   localparam int PAGE_W     = ADDR_W - OFF_W;
   localparam int SLOT_W     = $clog2(MEM_PAGES);
   localparam int RAM_AW     = SLOT_W + OFF_W;

   generate
      if (MEM_PAGES < 2 || (1 << SLOT_W) != MEM_PAGES)
         $error("MEM_PAGES must be a power of two of at least 2");
      if (SLOT_W >= PAGE_W)
         $error("MEM_PAGES must be below the addressable page count");
      if (WRITE_CYCLES < PAGE_BYTES + 2)
         $error("WRITE_CYCLES too short to sweep one page");
      if (OFF_W < 1 || DATA_W < 1)
         $error("OFF_W and DATA_W must be positive");
   endgenerate

   ppe_cmd_e cmd;
   logic do_start, do_commit, do_load, go;
   logic busy, done, any_valid, sel_valid;
   logic [DATA_W-1:0] sel_data, eng_rdata, merge_data;
   logic [OFF_W-1:0]  rd_idx, wr_idx;
   logic              wr_en;
   logic [SLOT_W-1:0] slot_q;
   logic              unused_hi;

   assign cmd       = decode_cmd(start_i, commit_i, load_i, busy);
   assign do_start  = (cmd == CMD_START);
   assign do_commit = (cmd == CMD_COMMIT);
   assign do_load   = (cmd == CMD_LOAD);
   assign go        = do_commit && any_valid;

   // only the page bits that index the simulated array are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        slot_q <= '0;
      else if (do_start) slot_q <= start_addr_i[OFF_W +: SLOT_W];
   end

   assign unused_hi = ^{start_addr_i[ADDR_W-1:OFF_W+SLOT_W],
                        rd_addr_i[ADDR_W-1:OFF_W+SLOT_W]};

   ppe_stage_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_stage (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (do_start),
      .start_off_i (start_addr_i[OFF_W-1:0]),
      .load_i      (do_load),
      .load_data_i (load_data_i),
      .clear_i     (done),
      .sel_idx_i   (wr_idx),
      .ptr_o       (cur_ptr_o),
      .any_valid_o (any_valid),
      .sel_data_o  (sel_data),
      .sel_valid_o (sel_valid)
   );

   ppe_sequencer #(.OFF_W(OFF_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_i     (go),
      .busy_o   (busy),
      .rd_idx_o (rd_idx),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .done_o   (done)
   );

   assign merge_data = sel_valid ? sel_data : eng_rdata;

   ppe_array #(.DATA_W(DATA_W), .AW(RAM_AW), .INIT_ERASED(1'b1)) u_array (
      .clk       (clk),
      .we_i      (wr_en),
      .waddr_i   ({slot_q, wr_idx}),
      .wdata_i   (merge_data),
      .raddr_a_i ({slot_q, rd_idx}),
      .rdata_a_o (eng_rdata),
      .raddr_b_i ({rd_addr_i[OFF_W +: SLOT_W], rd_addr_i[OFF_W-1:0]}),
      .rdata_b_o (rd_data_o)
   );

   assign busy_o = busy;
endmodule

// File: rtl/ppe_checker.sv
module ppe_checker #(
   parameter int ADDR_W       = 16,
   parameter int OFF_W        = 7,
   parameter int WRITE_CYCLES = 160
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] start_addr_i,
   input logic              load_i,
   input logic              commit_i,
   input logic              busy_o,
   input logic [OFF_W-1:0]  cur_ptr_o,
   input logic              any_valid
);
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_len <= 0;
      else if (busy_o) busy_len <= busy_len + 1;
      else             busy_len <= 0;
   end

   assert_start_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (cur_ptr_o == $past(start_addr_i[OFF_W-1:0])));

   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !start_i && !commit_i && !busy_o)
      |=> (cur_ptr_o == OFF_W'($past(cur_ptr_o) + 1'b1)));

   assert_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !start_i && !busy_o && any_valid) |=> busy_o);

   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (busy_len == WRITE_CYCLES));

   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(cur_ptr_o));

   assert_flags_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !any_valid);

   assert_empty_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !start_i && !busy_o && !any_valid) |=> !busy_o);
endmodule

bind page_prog_engine ppe_checker #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WRITE_CYCLES(WRITE_CYCLES)
) u_ppe_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .start_addr_i (start_addr_i),
   .load_i       (load_i),
   .commit_i     (commit_i),
   .busy_o       (busy_o),
   .cur_ptr_o    (cur_ptr_o),
   .any_valid    (any_valid)
);

// File: tb/page_prog_engine_bench.sv
module page_prog_engine_bench;
   localparam int WC        = 160;
   localparam int PAGES     = 4;
   localparam int MEM_BYTES = PAGES * 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] start_addr_i = '0;
   logic        load_i = 1'b0;
   logic [7:0]  load_data_i = '0;
   logic        commit_i = 1'b0;
   logic        busy_o;
   logic [6:0]  cur_ptr_o;
   logic [15:0] rd_addr_i = '0;
   logic [7:0]  rd_data_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   page_prog_engine #(.MEM_PAGES(PAGES), .WRITE_CYCLES(WC)) u_page_prog_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
      .load_i(load_i), .load_data_i(load_data_i), .commit_i(commit_i),
      .busy_o(busy_o), .cur_ptr_o(cur_ptr_o), .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o));

   // ---------------- behavioural reference ----------------
   int       m_mem [MEM_BYTES];
   int       m_stage [128];
   bit       m_vld [128];
   int       m_ptr, m_page, m_left;
   bit       m_busy;

   initial for (int i = 0; i < MEM_BYTES; i++) m_mem[i] = 255;

   function automatic int midx(input int page, input int off);
      return (page % PAGES) * 128 + off;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_left = 0; m_ptr = 0; m_page = 0;
         for (int i = 0; i < 128; i++) m_vld[i] = 0;
      end else if (m_busy) begin
         m_left = m_left - 1;
         if (m_left == 0) begin
            m_busy = 0;
            for (int i = 0; i < 128; i++) m_vld[i] = 0;
         end
      end else if (start_i) begin
         m_page = int'(start_addr_i[15:7]);
         m_ptr  = int'(start_addr_i[6:0]);
         for (int i = 0; i < 128; i++) m_vld[i] = 0;
      end else if (commit_i) begin
         int cnt;
         cnt = 0;
         for (int i = 0; i < 128; i++) if (m_vld[i]) cnt++;
         if (cnt > 0) begin
            for (int i = 0; i < 128; i++)
               if (m_vld[i]) m_mem[midx(m_page, i)] = m_stage[i];
            m_busy = 1;
            m_left = WC;
         end
      end else if (load_i) begin
         m_stage[m_ptr] = int'(load_data_i);
         m_vld[m_ptr]   = 1;
         m_ptr = (m_ptr + 1) % 128;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison of the visible state
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("R5/R7 busy_o per cycle", int'(busy_o), int'(m_busy));
         chk("R2/R3 cur_ptr_o per cycle", int'(cur_ptr_o), m_ptr);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_start(input logic [15:0] a);
      start_i = 1'b1; start_addr_i = a; tick(); start_i = 1'b0;
   endtask

   task automatic do_load(input logic [7:0] d);
      load_i = 1'b1; load_data_i = d; tick(); load_i = 1'b0;
   endtask

   task automatic do_commit();
      commit_i = 1'b1; tick(); commit_i = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy_o) tick();
   endtask

   task automatic rd(input logic [15:0] a, output int v);
      rd_addr_i = a; tick(); v = int'(rd_data_o);
   endtask

   task automatic check_page(input string tag, input int page);
      int v;
      for (int i = 0; i < 128; i++) begin
         rd(16'((page << 7) + i), v);
         chk(tag, v, m_mem[midx(page, i)]);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   // ---------------- test sequence ----------------
   initial begin
      int v, blen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state and erased array
      chk("R1 busy after reset", int'(busy_o), 0);
      chk("R1 ptr after reset", int'(cur_ptr_o), 0);
      rd(16'h0000, v); chk("R1 erased byte", v, 255);
      rd(16'h01FF, v); chk("R1 erased byte", v, 255);

      // R2, R3: start in page 1 at offset 5, three loads
      do_start(16'h0085);
      chk("R2 start offset", int'(cur_ptr_o), 5);
      do_load(8'h11); do_load(8'h22); do_load(8'h33);
      chk("R3 ptr after three loads", int'(cur_ptr_o), 8);

      // R5: busy length
      do_commit();
      blen = 0;
      while (busy_o) begin blen++; tick(); end
      chk("R5 busy length", blen, WC);

      // R6: merge result
      rd(16'h0085, v); chk("R6 new byte", v, 8'h11);
      rd(16'h0087, v); chk("R6 new byte", v, 8'h33);
      rd(16'h0084, v); chk("R6 untouched byte", v, 255);
      check_page("R6 page 1 sweep", 1);
      check_page("R6 page 0 untouched", 0);

      // R3: wrap from 127 to 0, merge keeps previous bytes
      do_start(16'h00FE);
      do_load(8'hA0); do_load(8'hA1); do_load(8'hA2); do_load(8'hA3);
      chk("R3 wrap ptr", int'(cur_ptr_o), 2);
      do_commit();
      // R7: requests during busy are dropped
      do_start(16'h0000);
      do_load(8'h5A);
      do_commit();
      chk("R7 ptr held during busy", int'(cur_ptr_o), 2);
      wait_idle();
      rd(16'h0080, v); chk("R3 wrapped byte", v, 8'hA2);
      rd(16'h0086, v); chk("R6 old byte kept", v, 8'h22);
      check_page("R6 page 1 after wrap", 1);
      rd(16'h0000, v); chk("R7 dropped load absent", v, 255);
      // R7: flags cleared at cycle end, so a bare commit does nothing
      do_commit();
      tick();
      chk("R7 commit after cycle end", int'(busy_o), 0);

      // R4: 130 loads into page 2 from offset 10
      do_start(16'h010A);
      for (int i = 0; i < 130; i++) do_load(8'(i + 1));
      chk("R4 ptr after 130 loads", int'(cur_ptr_o), 12);
      do_commit();
      wait_idle();
      rd(16'h010A, v); chk("R4 later byte wins", v, 129);
      rd(16'h010B, v); chk("R4 later byte wins", v, 130);
      rd(16'h010C, v); chk("R4 single load", v, 3);
      check_page("R6 page 2 sweep", 2);
      check_page("R6 page 3 untouched", 3);

      // R8: commit without loads
      do_start(16'h0180);
      do_commit();
      tick();
      chk("R8 no busy on empty commit", int'(busy_o), 0);
      rd(16'h0180, v); chk("R8 array unchanged", v, 255);

      // R9: page aliasing on the read port
      rd(16'h0285, v); chk("R9 alias of page 1", v, 8'h11);
      rd(16'h0306, v); chk("R9 alias of page 2", v, m_mem[midx(2, 6)]);

      // R10: start and load together, load dropped
      start_i = 1'b1; start_addr_i = 16'h0190; load_i = 1'b1; load_data_i = 8'hEE;
      tick();
      start_i = 1'b0; load_i = 1'b0;
      chk("R10 start wins ptr", int'(cur_ptr_o), 16);
      do_commit();
      tick();
      chk("R10 dropped load leaves nothing", int'(busy_o), 0);
      rd(16'h0190, v); chk("R10 array unchanged", v, 255);

      tick();
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule